// File: doc/BRIEF.md
# Interrupt Enable and Pending Register Bank

This block keeps the enable state and the pending state of every interrupt in a small interrupt distributor. Software reaches each state through two word arrays on a simple register bus. One array sets bits when a 1 is written, and the other clears bits when a 1 is written. Both arrays of a pair read back the same current state. Hardware interrupt lines also set the pending state. A forward request leaves the block for every interrupt that is both pending and enabled.

Every access carries a security attribute and a processor index. Interrupts that are not implemented, and secure-group interrupts seen by a non-secure access, read as zero and ignore writes. The first word, which covers IDs 0 to 31, has one copy per processor. A lock input freezes the enable state and the set-pending view of a parameterised range of secure shared interrupts. Read data appears on the cycle after the read strobe.

Top module: `irq_enable_pend_bank`

## Requirements
- R1: A write to the set-enable array (byte offset 0x100 + 4*n) sets each enable bit whose write-data bit is 1 and leaves the bits with write-data 0 unchanged. A read of that array returns the enable state.
- R2: A write to the clear-enable array (offset 0x180 + 4*n) clears each enable bit whose write-data bit is 1. A read returns the same enable state as the set-enable array.
- R3: A write to the set-pending array (offset 0x200 + 4*n) sets pending bits, and a write to the clear-pending array (offset 0x280 + 4*n) clears them. A read of either array returns the pending state.
- R4: Interrupt m is bit m MOD 32 of word m DIV 32. Word indices of LINES_NUM+1 or more, and any address outside the four arrays, read as zero and ignore writes. Address bits [1:0] are ignored.
- R5: A bit whose impl_i bit is 0 reads as zero and ignores writes.
- R6: When sec_i is 0, a bit whose group_i bit is 0 (secure group) reads as zero and ignores writes. When sec_i is 1, every implemented bit is accessible.
- R7: Word 0 has one copy per processor, selected by cpu_i. Copy c drives bits [32c+31:32c] of the bank_* outputs. A cpu_i value of NUM_CPU or more selects no copy.
- R8: Writes to either pending array leave the pending bits of IDs 0 to 15 unchanged.
- R9: A high hardware interrupt input sets its pending bit on the next clock edge, whatever the enable state. In the same cycle the input takes precedence over a clear-pending write.
- R10: Each forward output bit equals pending AND enabled for that interrupt.
- R11: While lock_i is 1, writes to the set-enable, clear-enable and set-pending arrays leave unchanged the bits of shared IDs 32 to 32+LOCK_SPI-1 that are in the secure group. Clear-pending writes are not affected.
- R12: rdata_o takes the read value on the clock edge that samples rd_i and holds it while rd_i is 0. After reset, all state and rdata_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| sec_i | input | 1 | 1 = secure access |
| cpu_i | input | CPU_W | Processor index of the access |
| lock_i | input | 1 | Lock of secure lockable shared interrupts |
| group_i | input | N_IRQ | Group per ID, 0 = secure |
| impl_i | input | N_IRQ | Implemented mask per ID |
| bank_irq_i | input | NUM_CPU*32 | Hardware inputs for the per-processor IDs 0 to 31 |
| spi_irq_i | input | N_SPI | Hardware inputs for the shared IDs 32 and up |
| rdata_o | output | 32 | Registered read data |
| bank_en_o | output | NUM_CPU*32 | Per-processor enable state |
| bank_pend_o | output | NUM_CPU*32 | Per-processor pending state |
| bank_fwd_o | output | NUM_CPU*32 | Per-processor forward requests |
| spi_en_o | output | N_SPI | Shared enable state |
| spi_pend_o | output | N_SPI | Shared pending state |
| spi_fwd_o | output | N_SPI | Shared forward requests |

## Verification
The bench writes to a disabled interrupt while its input is high, and checks that the pending bit still sets. A design that gated pending with the enable bit would lose that request. It also raises an input in the same cycle as a clear-pending write, where the wrong precedence drops the edge. It makes non-secure and locked writes to secure bits, and writes to the software-generated pending bits; a missing filter shows up there as a changed enable or pending output. The bench also accesses word 0 from each processor in turn and touches word indices past the last implemented word, where a wrong bank select or a wrapped decode would corrupt another copy or return nonzero data.

// File: rtl/irq_eb_pkg.sv
package irq_eb_pkg;
  localparam int WORD_BITS = 32;
  localparam int SGI_NUM   = 16;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_SET_EN,
    ACC_CLR_EN,
    ACC_SET_PD,
    ACC_CLR_PD
  } acc_kind_e;
endpackage

// File: rtl/irq_eb_decode.sv
module irq_eb_decode
  import irq_eb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NWORDS = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [4:0]        word_o,
  output logic              hit_o
);
  logic in_page;

  always_comb begin
    in_page = ((addr_i >> 10) == '0);
    word_o  = addr_i[6:2];
    kind_o  = ACC_NONE;
    if (in_page) begin
      case (addr_i[9:7])
        3'd2:    kind_o = ACC_SET_EN;
        3'd3:    kind_o = ACC_CLR_EN;
        3'd4:    kind_o = ACC_SET_PD;
        3'd5:    kind_o = ACC_CLR_PD;
        default: kind_o = ACC_NONE;
      endcase
    end
    hit_o = (kind_o != ACC_NONE) && (int'(word_o) < NWORDS);
  end
endmodule

// File: rtl/irq_eb_mask.sv
module irq_eb_mask
  import irq_eb_pkg::*;
#(
  parameter int NWORDS   = 2,
  parameter int LOCK_SPI = 8,
  localparam int N_IRQ   = NWORDS * WORD_BITS
) (
  input  logic [4:0]           word_i,
  input  logic                 sec_i,
  input  logic                 lock_i,
  input  logic [N_IRQ-1:0]     group_i,
  input  logic [N_IRQ-1:0]     impl_i,
  output logic [WORD_BITS-1:0] rd_mask_o,
  output logic [WORD_BITS-1:0] wm_en_o,
  output logic [WORD_BITS-1:0] wm_spd_o,
  output logic [WORD_BITS-1:0] wm_cpd_o
);
  logic [4:0]           widx;
  logic [WORD_BITS-1:0] grp_w, impl_w, lockable, locked, sgi;

  always_comb begin
    widx   = (int'(word_i) < NWORDS) ? word_i : 5'd0;
    grp_w  = group_i[widx*WORD_BITS +: WORD_BITS];
    impl_w = impl_i[widx*WORD_BITS +: WORD_BITS];
    for (int b = 0; b < WORD_BITS; b++) begin
      lockable[b] = (int'(widx) * WORD_BITS + b >= WORD_BITS) &&
                    (int'(widx) * WORD_BITS + b <  WORD_BITS + LOCK_SPI);
    end
    sgi       = (widx == 5'd0) ? WORD_BITS'((64'd1 << SGI_NUM) - 64'd1) : '0;
    rd_mask_o = impl_w & (sec_i ? '1 : grp_w);
    locked    = lock_i ? (lockable & ~grp_w) : '0;
    wm_en_o   = rd_mask_o & ~locked;
    wm_spd_o  = wm_en_o & ~sgi;
    wm_cpd_o  = rd_mask_o & ~sgi;
  end
endmodule

// File: rtl/irq_enable_pend_bank.sv
module irq_enable_pend_bank
  import irq_eb_pkg::*;
#(
  parameter int  LINES_NUM = 1,
  parameter int  NUM_CPU   = 2,
  parameter int  LOCK_SPI  = 8,
  parameter int  ADDR_W    = 12,
  localparam int NWORDS    = LINES_NUM + 1,
  localparam int N_IRQ     = NWORDS * WORD_BITS,
  localparam int N_SPI     = LINES_NUM * WORD_BITS,
  localparam int N_BANK    = NUM_CPU * WORD_BITS,
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [WORD_BITS-1:0] wdata_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic                 sec_i,
  input  logic [CPU_W-1:0]     cpu_i,
  input  logic                 lock_i,
  input  logic [N_IRQ-1:0]     group_i,
  input  logic [N_IRQ-1:0]     impl_i,
  input  logic [N_BANK-1:0]    bank_irq_i,
  input  logic [N_SPI-1:0]     spi_irq_i,
  output logic [WORD_BITS-1:0] rdata_o,
  output logic [N_BANK-1:0]    bank_en_o,
  output logic [N_BANK-1:0]    bank_pend_o,
  output logic [N_BANK-1:0]    bank_fwd_o,
  output logic [N_SPI-1:0]     spi_en_o,
  output logic [N_SPI-1:0]     spi_pend_o,
  output logic [N_SPI-1:0]     spi_fwd_o
);
  acc_kind_e            kind;
  logic [4:0]           word;
  logic                 hit, wr_act;
  logic [WORD_BITS-1:0] rd_mask, wm_en, wm_spd, wm_cpd;
  logic [WORD_BITS-1:0] set_en_v, clr_en_v, set_pd_v, clr_pd_v;
  logic [WORD_BITS-1:0] cur_en, cur_pd, rdata_d, rdata_q;

  irq_eb_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS)) u_dec (
    .addr_i (addr_i),
    .kind_o (kind),
    .word_o (word),
    .hit_o  (hit)
  );

  irq_eb_mask #(.NWORDS(NWORDS), .LOCK_SPI(LOCK_SPI)) u_mask (
    .word_i    (word),
    .sec_i     (sec_i),
    .lock_i    (lock_i),
    .group_i   (group_i),
    .impl_i    (impl_i),
    .rd_mask_o (rd_mask),
    .wm_en_o   (wm_en),
    .wm_spd_o  (wm_spd),
    .wm_cpd_o  (wm_cpd)
  );

  // Per-word write vectors, already filtered by the access masks
  always_comb begin
    wr_act   = wr_i & hit;
    set_en_v = (wr_act && kind == ACC_SET_EN) ? (wdata_i & wm_en)  : '0;
    clr_en_v = (wr_act && kind == ACC_CLR_EN) ? (wdata_i & wm_en)  : '0;
    set_pd_v = (wr_act && kind == ACC_SET_PD) ? (wdata_i & wm_spd) : '0;
    clr_pd_v = (wr_act && kind == ACC_CLR_PD) ? (wdata_i & wm_cpd) : '0;
  end

  // Banked word 0, one copy per processor
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic                 sel, en_ce, pd_ce;
    logic [WORD_BITS-1:0] en_q, en_d, pd_q, pd_d, irq_w;

    always_comb begin
      irq_w = bank_irq_i[c*WORD_BITS +: WORD_BITS];
      sel   = (word == 5'd0) && (cpu_i == CPU_W'(c));
      en_ce = sel & wr_act;
      pd_ce = en_ce | (|irq_w);
      en_d  = sel ? ((en_q | set_en_v) & ~clr_en_v) : en_q;
      pd_d  = (sel ? ((pd_q & ~clr_pd_v) | set_pd_v) : pd_q) | irq_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= '0;
        pd_q <= '0;
      end else begin
        if (en_ce) en_q <= en_d;
        if (pd_ce) pd_q <= pd_d;
      end
    end

    assign bank_en_o[c*WORD_BITS +: WORD_BITS]   = en_q;
    assign bank_pend_o[c*WORD_BITS +: WORD_BITS] = pd_q;
  end

  // Shared words 1..LINES_NUM
  for (genvar w = 1; w <= LINES_NUM; w++) begin : g_spi
    logic                 sel, en_ce, pd_ce;
    logic [WORD_BITS-1:0] en_q, en_d, pd_q, pd_d, irq_w;

    always_comb begin
      irq_w = spi_irq_i[(w-1)*WORD_BITS +: WORD_BITS];
      sel   = (word == 5'(w));
      en_ce = sel & wr_act;
      pd_ce = en_ce | (|irq_w);
      en_d  = sel ? ((en_q | set_en_v) & ~clr_en_v) : en_q;
      pd_d  = (sel ? ((pd_q & ~clr_pd_v) | set_pd_v) : pd_q) | irq_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q <= '0;
        pd_q <= '0;
      end else begin
        if (en_ce) en_q <= en_d;
        if (pd_ce) pd_q <= pd_d;
      end
    end

    assign spi_en_o[(w-1)*WORD_BITS +: WORD_BITS]   = en_q;
    assign spi_pend_o[(w-1)*WORD_BITS +: WORD_BITS] = pd_q;
  end

  assign bank_fwd_o = bank_en_o & bank_pend_o;
  assign spi_fwd_o  = spi_en_o & spi_pend_o;

  // Read path
  always_comb begin
    cur_en = '0;
    cur_pd = '0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (word == 5'd0 && cpu_i == CPU_W'(c)) begin
        cur_en = bank_en_o[c*WORD_BITS +: WORD_BITS];
        cur_pd = bank_pend_o[c*WORD_BITS +: WORD_BITS];
      end
    end
    for (int w = 1; w <= LINES_NUM; w++) begin
      if (word == 5'(w)) begin
        cur_en = spi_en_o[(w-1)*WORD_BITS +: WORD_BITS];
        cur_pd = spi_pend_o[(w-1)*WORD_BITS +: WORD_BITS];
      end
    end
    if (!hit)
      rdata_d = '0;
    else if (kind == ACC_SET_EN || kind == ACC_CLR_EN)
      rdata_d = cur_en & rd_mask;
    else
      rdata_d = cur_pd & rd_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_eb_checker.sv
module irq_eb_checker #(
  parameter int  LINES_NUM = 1,
  parameter int  NUM_CPU   = 2,
  parameter int  LOCK_SPI  = 8,
  parameter int  ADDR_W    = 12,
  localparam int N_IRQ     = (LINES_NUM + 1) * 32,
  localparam int N_SPI     = LINES_NUM * 32,
  localparam int N_BANK    = NUM_CPU * 32,
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic              sec_i,
  input logic [CPU_W-1:0]  cpu_i,
  input logic              lock_i,
  input logic [N_IRQ-1:0]  group_i,
  input logic [N_IRQ-1:0]  impl_i,
  input logic [N_BANK-1:0] bank_irq_i,
  input logic [N_SPI-1:0]  spi_irq_i,
  input logic [31:0]       rdata_o,
  input logic [N_BANK-1:0] bank_en_o,
  input logic [N_BANK-1:0] bank_pend_o,
  input logic [N_BANK-1:0] bank_fwd_o,
  input logic [N_SPI-1:0]  spi_en_o,
  input logic [N_SPI-1:0]  spi_pend_o,
  input logic [N_SPI-1:0]  spi_fwd_o
);
  logic [N_BANK-1:0] sgi_m;
  logic [N_SPI-1:0]  lock_m;

  always_comb begin
    for (int i = 0; i < N_BANK; i++) sgi_m[i] = ((i % 32) < 16);
    for (int i = 0; i < N_SPI; i++)  lock_m[i] = (i < LOCK_SPI) && !group_i[32+i];
  end

  AST_SPI_PEND_BY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (|spi_irq_i) |=> ((spi_pend_o & $past(spi_irq_i)) == $past(spi_irq_i))); // R9
  AST_BANK_PEND_BY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_irq_i) |=> ((bank_pend_o & $past(bank_irq_i)) == $past(bank_irq_i))); // R9
  AST_UNIMPL_EN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (((spi_en_o ^ $past(spi_en_o)) & ~$past(impl_i[N_IRQ-1:32])) == '0)); // R5
  AST_NS_SECURE_EN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_i |=> (((spi_en_o ^ $past(spi_en_o)) & ~$past(group_i[N_IRQ-1:32])) == '0)); // R6
  AST_LOCKED_EN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> (((spi_en_o ^ $past(spi_en_o)) & $past(lock_m)) == '0)); // R11
  AST_SGI_PEND_ONLY_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_pend_o & ~$past(bank_pend_o) & sgi_m & ~$past(bank_irq_i)) == '0)); // R8
  AST_FWD_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (((spi_fwd_o & ~(spi_en_o & spi_pend_o)) == '0) &&
     ((bank_fwd_o & ~(bank_en_o & bank_pend_o)) == '0))); // R10
  AST_READ_OUTSIDE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && ((addr_i >> 10) != '0)) |=> (rdata_o == '0)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o)); // R12
endmodule

bind irq_enable_pend_bank irq_eb_checker #(
  .LINES_NUM (LINES_NUM),
  .NUM_CPU   (NUM_CPU),
  .LOCK_SPI  (LOCK_SPI),
  .ADDR_W    (ADDR_W)
) u_chk (.*);

// File: tb/tb_irq_enable_pend_bank.sv
`timescale 1ns/1ps
module tb_irq_enable_pend_bank;
  localparam int LINES  = 2;
  localparam int NCPU   = 2;
  localparam int LOCKN  = 8;
  localparam int NW     = LINES + 1;
  localparam int N_IRQ  = NW * 32;
  localparam int N_SPI  = LINES * 32;
  localparam int N_BANK = NCPU * 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [11:0]       addr;
  logic [31:0]       wdata, rdata;
  logic              wr, rd, sec, lock;
  logic [0:0]        cpu;
  logic [N_IRQ-1:0]  grp, impl;
  logic [N_BANK-1:0] birq, ben, bpd, bfwd;
  logic [N_SPI-1:0]  sirq, sen, spd, sfwd;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  logic [31:0] m_en [NW*NCPU];
  logic [31:0] m_pd [NW*NCPU];
  logic [31:0] exp_rd;

  always #2 clk = ~clk;

  irq_enable_pend_bank #(.LINES_NUM(LINES), .NUM_CPU(NCPU), .LOCK_SPI(LOCKN), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .sec_i(sec), .cpu_i(cpu), .lock_i(lock), .group_i(grp), .impl_i(impl),
    .bank_irq_i(birq), .spi_irq_i(sirq), .rdata_o(rdata),
    .bank_en_o(ben), .bank_pend_o(bpd), .bank_fwd_o(bfwd),
    .spi_en_o(sen), .spi_pend_o(spd), .spi_fwd_o(sfwd)
  );

  // Model slot: banked word 0 for cpu c at slot c, shared word w at slot NCPU+w-1
  function automatic int slot(input int w, input int c);
    return (w == 0) ? c : NCPU + w - 1;
  endfunction

  function automatic logic [31:0] acc_mask(input int w, input logic s);
    return impl[w*32 +: 32] & (s ? 32'hFFFF_FFFF : grp[w*32 +: 32]);
  endfunction

  function automatic logic [31:0] lock_mask(input int w);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) begin
      int id = w * 32 + b;
      m[b] = lock && id >= 32 && id < 32 + LOCKN && !grp[id];
    end
    return m;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [N_BANK-1:0] eb_en, eb_pd;
    logic [N_SPI-1:0]  es_en, es_pd;
    for (int c = 0; c < NCPU; c++) begin
      eb_en[c*32 +: 32] = m_en[c];
      eb_pd[c*32 +: 32] = m_pd[c];
    end
    for (int w = 1; w <= LINES; w++) begin
      es_en[(w-1)*32 +: 32] = m_en[slot(w, 0)];
      es_pd[(w-1)*32 +: 32] = m_pd[slot(w, 0)];
    end
    check({tag, " bank enable"}, 128'(ben), 128'(eb_en));
    check({tag, " bank pending"}, 128'(bpd), 128'(eb_pd));
    check({tag, " shared enable"}, 128'(sen), 128'(es_en));
    check({tag, " shared pending"}, 128'(spd), 128'(es_pd));
    check("R10 bank forward", 128'(bfwd), 128'(eb_en & eb_pd));
    check("R10 shared forward", 128'(sfwd), 128'(es_en & es_pd));
    check({tag, " read data"}, 128'(rdata), 128'(exp_rd));
  endtask

  // One bus cycle; entered and left at a falling edge
  task automatic cyc(input logic w_, input logic r_, input logic [11:0] a, input logic [31:0] d,
                     input logic s, input int c, input string tag);
    int  kind, word, sl;
    logic hitv, lk_ok;
    logic [31:0] am, wm;
    addr = a; wdata = d; wr = w_; rd = r_; sec = s; cpu = c[0:0];
    word = int'(a[6:2]);
    kind = ((a >> 10) == 0) ? int'(a[9:7]) : 0;
    hitv = (kind >= 2 && kind <= 5) && word < NW && (word != 0 || c < NCPU);
    sl   = slot(word, c);
    if (r_) begin
      if (!hitv) exp_rd = '0;
      else exp_rd = ((kind <= 3) ? m_en[sl] : m_pd[sl]) & acc_mask(word, s);
    end
    if (w_ && hitv) begin
      am = acc_mask(word, s);
      wm = am & ~lock_mask(word);
      lk_ok = 1'b1;
      case (kind)
        2: m_en[sl] = m_en[sl] | (d & wm);
        3: m_en[sl] = m_en[sl] & ~(d & wm);
        4: m_pd[sl] = m_pd[sl] | (d & wm & ((word == 0) ? 32'hFFFF_0000 : 32'hFFFF_FFFF));
        5: m_pd[sl] = m_pd[sl] & ~(d & am & ((word == 0) ? 32'hFFFF_0000 : 32'hFFFF_FFFF));
        default: lk_ok = 1'b0;
      endcase
    end
    for (int k = 0; k < NCPU; k++) m_pd[k] = m_pd[k] | birq[k*32 +: 32];
    for (int k = 1; k <= LINES; k++) m_pd[slot(k, 0)] = m_pd[slot(k, 0)] | sirq[(k-1)*32 +: 32];
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    compare_all(tag);
  endtask

  function automatic logic [11:0] ad(input int base, input int w);
    return 12'(base + 4 * w);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; addr = '0; wdata = '0; wr = 0; rd = 0; sec = 0; cpu = '0; lock = 0;
    birq = '0; sirq = '0;
    impl = {32'h00FF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0FFF};
    grp  = {$urandom, $urandom, $urandom};
    grp[39:32] = 8'hA5;
    grp[0]     = 1'b0;
    for (int i = 0; i < NW*NCPU; i++) begin m_en[i] = '0; m_pd[i] = '0; end
    exp_rd = '0;
    repeat (3) @(negedge clk);
    compare_all("R12 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R5: secure set-enable on word 1, read through both enable views
    cyc(1, 0, ad(12'h100, 1), 32'hFFFF_FFFF, 1, 0, "R1 set-enable");
    cyc(0, 1, ad(12'h100, 1), 0, 1, 0, "R1 read");
    check("R5 impl mask word1", 128'(rdata), 128'(impl[63:32]));
    cyc(0, 1, ad(12'h180, 1), 0, 1, 0, "R2 read clear view");
    // R6: non-secure sees only group 1
    cyc(0, 1, ad(12'h100, 1), 0, 0, 0, "R6 ns read");
    check("R6 ns read value", 128'(rdata), 128'(impl[63:32] & grp[63:32]));
    cyc(1, 0, ad(12'h180, 1), 32'hFFFF_FFFF, 0, 0, "R6 ns clear");
    cyc(1, 0, ad(12'h180, 1), 32'h0000_000F, 1, 0, "R2 secure clear");
    // R5 word 2 partly unimplemented; R4 word 3 and page outside
    cyc(1, 0, ad(12'h100, 2), 32'hFFFF_FFFF, 1, 0, "R5 set word2");
    cyc(0, 1, ad(12'h100, 2), 0, 1, 0, "R5 read word2");
    check("R5 unimplemented zero", 128'(rdata[31:24]), 128'(0));
    cyc(1, 0, ad(12'h100, 3), 32'hFFFF_FFFF, 1, 0, "R4 write word3");
    cyc(0, 1, ad(12'h100, 3), 0, 1, 0, "R4 read word3");
    cyc(1, 0, 12'h500, 32'hFFFF_FFFF, 1, 0, "R4 outside page");
    cyc(0, 1, 12'h500, 0, 1, 0, "R4 read outside");
    cyc(0, 1, 12'h107, 0, 1, 0, "R4 low addr bits ignored");
    // R7: banked word 0
    cyc(1, 0, ad(12'h100, 0), 32'hA5A5_A5A5, 1, 0, "R7 cpu0 set");
    cyc(1, 0, ad(12'h100, 0), 32'h5A5A_5A5A, 1, 1, "R7 cpu1 set");
    cyc(0, 1, ad(12'h100, 0), 0, 1, 0, "R7 cpu0 read");
    check("R7 cpu0 copy", 128'(rdata), 128'(32'hA5A5_A5A5 & impl[31:0]));
    cyc(0, 1, ad(12'h100, 0), 0, 1, 1, "R7 cpu1 read");
    // R8: software-generated pending bits ignore writes
    cyc(1, 0, ad(12'h200, 0), 32'hFFFF_FFFF, 1, 0, "R8 set-pend word0");
    cyc(0, 1, ad(12'h200, 0), 0, 1, 0, "R8 read");
    check("R8 sgi pend low", 128'(rdata[15:0]), 128'(0));
    birq = 64'h0000_0000_0000_0003;
    cyc(0, 0, 0, 0, 1, 0, "R9 sgi by input");
    birq = '0;
    cyc(1, 0, ad(12'h280, 0), 32'hFFFF_FFFF, 1, 0, "R8 clear-pend word0");
    // R9: pending sets while disabled; input beats a clear in the same cycle
    cyc(1, 0, ad(12'h180, 1), 32'hFFFF_FFFF, 1, 0, "R2 disable word1");
    sirq = 64'h0000_0000_8000_0001;
    cyc(0, 0, 0, 0, 1, 0, "R9 pend while disabled");
    check("R9 shared pend bit0", 128'(spd[0]), 128'(1));
    cyc(1, 0, ad(12'h280, 1), 32'hFFFF_FFFF, 1, 0, "R9 input beats clear");
    sirq = '0;
    cyc(1, 0, ad(12'h280, 1), 32'hFFFF_FFFF, 1, 0, "R3 clear-pend");
    cyc(1, 0, ad(12'h200, 1), 32'h0F0F_0F0F, 1, 0, "R3 set-pend");
    cyc(1, 0, ad(12'h100, 1), 32'h00FF_00FF, 1, 0, "R10 enable part");
    cyc(0, 1, ad(12'h280, 1), 0, 1, 0, "R3 read clear-pend view");
    // R11: lockdown
    lock = 1'b1;
    cyc(1, 0, ad(12'h100, 1), 32'hFFFF_FFFF, 1, 0, "R11 locked set-en");
    cyc(1, 0, ad(12'h180, 1), 32'h0000_00FF, 1, 0, "R11 locked clr-en");
    cyc(1, 0, ad(12'h200, 1), 32'h0000_00FF, 1, 0, "R11 locked set-pend");
    cyc(1, 0, ad(12'h280, 1), 32'h0000_00FF, 1, 0, "R11 clear-pend unlocked");
    lock = 1'b0;

    // Random phase
    for (int i = 0; i < 1500; i++) begin
      int bsel;
      logic [11:0] a;
      bsel = $urandom_range(0, 15);
      case (bsel % 5)
        0: a = ad(12'h100, $urandom_range(0, 3));
        1: a = ad(12'h180, $urandom_range(0, 3));
        2: a = ad(12'h200, $urandom_range(0, 3));
        3: a = ad(12'h280, $urandom_range(0, 3));
        default: a = 12'($urandom_range(0, 4095)) & 12'hFFC;
      endcase
      lock = ($urandom_range(0, 3) == 0);
      sirq = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      birq = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      cyc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, $urandom,
          $urandom_range(0, 1) == 1, $urandom_range(0, 1), "R1 R3 R6 R11 random");
    end
    sirq = '0; birq = '0; lock = 0;
    cyc(0, 0, 0, 0, 1, 0, "R12 idle hold");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule